// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block makes sure an SDRAM memory controller refreshes the device on time. A free-running interval counter adds one owed refresh every `TREFI` clocks. While at least one refresh is owed, the block asks the main command scheduler for the command bus. Once it has the bus, it sends a close-all-banks command if any bank is still open. It then waits out the precharge time, sends REFRESH, and keeps the bus until the refresh cycle time has passed. The whole sequence runs as one uninterrupted handover.

The main scheduler keeps command issue while `req` is low. It hands the bus over by raising `grant` while `req` is high, and it must send nothing while `busy` is high. The main scheduler reports each bank's open state on `bank_open`. It pulses `ext_pre` whenever it sends a precharge of its own, so that the precharge time already served counts towards the wait. The device keeps its own refresh row counter, so no address leaves this block. If the main scheduler keeps withholding the grant, owed refreshes pile up to a bounded limit and `urgent` goes high. Temperature-based rate changes are not part of this block.

Top module: `refsch_top`

## Requirements
- R1: One refresh becomes owed every `TREFI` cycles, counted from reset release. The first `req` appears in cycle `TREFI`+1, where cycle 0 is the first cycle out of reset. The interval counter also runs during a refresh sequence, so with `grant` held high the REFRESH count over N cycles is N/`TREFI` within one.
- R2: After reset, `req`, `busy`, `urgent` and `cmd_valid` are low. `req` is never high together with `busy`. No command is sent until `grant` has been sampled high while `req` was high.
- R3: `busy` rises in the cycle after `grant` is sampled with `req` high. It is high in every cycle that carries a command. It falls exactly `TRFC` cycles after the REFRESH cycle.
- R4: If any bit of `bank_open` is set when the grant is taken, close-all (`cmd_op` = 2'b01) is sent in the next cycle. REFRESH (`cmd_op` = 2'b10) follows exactly `TRP` cycles after it. `cmd_op` is 2'b00 whenever `cmd_valid` is low. REFRESH is never sent fewer than `TRP` cycles after the latest precharge.
- R5: If no bank is open and no precharge occurred in the last `TRP` cycles, no close-all is sent. REFRESH is sent two cycles after the grant cycle.
- R6: An `ext_pre` pulse restarts the precharge wait. When `ext_pre` and the grant fall in the same cycle, REFRESH comes exactly `TRP` cycles after that cycle.
- R7: Two REFRESH commands are always at least `TRFC` cycles apart.
- R8: At most `MAX_PEND` refreshes can be owed. `urgent` rises when that count is reached, (`MAX_PEND`-1)·`TREFI`-1 cycles after the first `req`. Ticks that arrive at the limit are dropped. Draining a full backlog with `grant` held high gives exactly `MAX_PEND` REFRESH commands and then drops `urgent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Main scheduler hands over the command bus |
| bank_open | input | NBANK | One bit per bank, high while that bank holds an open row |
| ext_pre | input | 1 | Pulse: main scheduler sent a precharge this cycle |
| req | output | 1 | Refresh owed, bus requested |
| busy | output | 1 | Refresh sequence owns the bus |
| urgent | output | 1 | Owed-refresh count at its limit |
| cmd_valid | output | 1 | A command is on `cmd_op` this cycle |
| cmd_op | output | 2 | 2'b01 close all banks, 2'b10 refresh, 2'b00 none |

## Verification
The bench builds the block with `TREFI`=40, `TRP`=3, `TRFC`=6, `MAX_PEND`=4 and `NBANK`=4. These values fill the backlog within a few hundred cycles. A full drain then fits between two interval ticks, so an exact count of issued refreshes shows whether ticks at the limit are dropped. `TRP`=3 makes the skip path (REFRESH two cycles after the grant) differ from the `ext_pre` path (three cycles). `TRFC`=6 keeps back-to-back refreshes short enough that twenty intervals run in well under a thousand cycles for the rate check.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GRANT,
    ST_PREA,
    ST_WAIT_TRP,
    ST_ISSUE_REF,
    ST_WAIT_TRFC,
    ST_RELEASE
  } rs_state_e;

  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_PREA = 2'b01;
  localparam logic [1:0] OP_REF  = 2'b10;

  // Value the lockout timer is loaded with so that busy ends trfc cycles after REFRESH
  function automatic int unsigned lock_load_value(int unsigned trfc);
    return trfc - 2;
  endfunction

  // Precharge-age at which the FSM may move on, so REFRESH lands at age trp
  function automatic int unsigned trp_ready_age(int unsigned trp);
    return (trp > 0) ? trp - 1 : 0;
  endfunction

endpackage

// File: rtl/refsch_pacer.sv
module refsch_pacer #(
  parameter int TREFI    = 1560,
  parameter int MAX_PEND = 8,
  parameter int PW       = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          consume,
  output logic          tick,
  output logic [PW-1:0] pend,
  output logic          pend_any,
  output logic          pend_full
);
  localparam int CW = $clog2(TREFI);
  localparam logic [CW-1:0] LAST = CW'(TREFI - 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);

  logic [CW-1:0] icnt;

  assign tick      = (icnt == LAST);
  assign pend_any  = (pend != '0);
  assign pend_full = (pend == PMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) icnt <= '0;
    else if (tick) icnt <= '0;
    else icnt <= icnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else if (tick && !consume && !pend_full) pend <= pend + 1'b1;
    else if (consume && !tick) pend <= pend - 1'b1;
  end
endmodule

// File: rtl/refsch_gap.sv
module refsch_gap import refsch_pkg::*; #(
  parameter int TRP = 6,
  parameter int GW  = $clog2(TRP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_evt,
  output logic [GW-1:0] gap,
  output logic          trp_ok
);
  localparam logic [GW-1:0] GMAX  = GW'(TRP);
  localparam logic [GW-1:0] READY = GW'(trp_ready_age(TRP));

  assign trp_ok = (gap >= READY);

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= GMAX;
    else if (pre_evt) gap <= GW'(1);
    else if (gap != GMAX) gap <= gap + 1'b1;
  end
endmodule

// File: rtl/refsch_lockout.sv
module refsch_lockout import refsch_pkg::*; #(
  parameter int TRFC = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int LW = (TRFC > 2) ? $clog2(TRFC) : 1;
  localparam logic [LW-1:0] LOADV = LW'(lock_load_value(TRFC));

  logic [LW-1:0] lcnt;

  assign done = (lcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) lcnt <= '0;
    else if (load) lcnt <= LOADV;
    else if (!done) lcnt <= lcnt - 1'b1;
  end
endmodule

// File: rtl/refsch_top.sv
module refsch_top import refsch_pkg::*; #(
  parameter int TREFI    = 1560,
  parameter int TRP      = 6,
  parameter int TRFC     = 88,
  parameter int MAX_PEND = 8,
  parameter int NBANK    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [NBANK-1:0] bank_open,
  input  logic             ext_pre,
  output logic             req,
  output logic             busy,
  output logic             urgent,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int GW = $clog2(TRP + 1);

  rs_state_e st, st_nxt;

  logic          tick;
  logic [PW-1:0] pend;
  logic          pend_any, pend_full;
  logic [GW-1:0] gap;
  logic          trp_ok, lock_done;
  logic          pre_fire, ref_fire, pre_evt, any_open;

  assign any_open = |bank_open;
  assign pre_fire = (st == ST_PREA);
  assign ref_fire = (st == ST_ISSUE_REF);
  assign pre_evt  = pre_fire | ext_pre;

  refsch_pacer #(.TREFI(TREFI), .MAX_PEND(MAX_PEND), .PW(PW)) u_pacer (
    .clk(clk), .rst_n(rst_n), .consume(ref_fire), .tick(tick),
    .pend(pend), .pend_any(pend_any), .pend_full(pend_full)
  );

  refsch_gap #(.TRP(TRP), .GW(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .pre_evt(pre_evt), .gap(gap), .trp_ok(trp_ok)
  );

  refsch_lockout #(.TRFC(TRFC)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(ref_fire), .done(lock_done)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:       if (pend_any) st_nxt = ST_WAIT_GRANT;
      ST_WAIT_GRANT: if (grant) st_nxt = any_open ? ST_PREA : ST_WAIT_TRP;
      ST_PREA:       st_nxt = ST_WAIT_TRP;
      ST_WAIT_TRP:   if (trp_ok) st_nxt = ST_ISSUE_REF;
      ST_ISSUE_REF:  st_nxt = ST_WAIT_TRFC;
      ST_WAIT_TRFC:  if (lock_done) st_nxt = ST_RELEASE;
      ST_RELEASE:    st_nxt = pend_any ? ST_WAIT_GRANT : ST_IDLE;
      default:       st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else st <= st_nxt;
  end

  assign req       = (st == ST_WAIT_GRANT);
  assign busy      = (st == ST_PREA) || (st == ST_WAIT_TRP) ||
                     (st == ST_ISSUE_REF) || (st == ST_WAIT_TRFC);
  assign urgent    = pend_full;
  assign cmd_valid = pre_fire | ref_fire;
  assign cmd_op    = pre_fire ? OP_PREA : (ref_fire ? OP_REF : OP_NONE);

  logic unused_tick;
  assign unused_tick = tick;
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
  parameter int TRP      = 6,
  parameter int TRFC     = 88,
  parameter int MAX_PEND = 8,
  parameter int GW       = 3,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grant,
  input logic          req,
  input logic          busy,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [GW-1:0] gap,
  input logic [PW-1:0] pend
);
  localparam int SW = $clog2(TRFC + 1);

  logic          ref_now;
  logic          seen_ref;
  logic [SW-1:0] since_ref;

  assign ref_now = cmd_valid && (cmd_op == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_ref  <= 1'b0;
      since_ref <= '0;
    end else if (ref_now) begin
      seen_ref  <= 1'b1;
      since_ref <= SW'(1);
    end else if (int'(since_ref) < TRFC) begin
      since_ref <= since_ref + 1'b1;
    end
  end

  AST_REF_AFTER_TRP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_now |-> int'(gap) >= TRP); // R4
  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_now && seen_ref) |-> int'(since_ref) >= TRFC); // R7
  AST_CMD_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy); // R3
  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && grant)); // R3
  AST_REQ_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && busy)); // R2
  AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op == 2'b01 || cmd_op == 2'b10)); // R4
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_op == 2'b00); // R4
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend) <= MAX_PEND); // R8
endmodule

bind refsch_top refsch_chk #(
  .TRP(TRP), .TRFC(TRFC), .MAX_PEND(MAX_PEND), .GW(GW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .busy(busy),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .gap(gap), .pend(pend)
);

// File: tb/sim_refsch_top.sv
`timescale 1ns/1ps
module sim_refsch_top;
  localparam int TREFI    = 40;
  localparam int TRP      = 3;
  localparam int TRFC     = 6;
  localparam int MAX_PEND = 4;
  localparam int NBANK    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             grant = 1'b0;
  logic [NBANK-1:0] bank_open = '0;
  logic             ext_pre = 1'b0;
  logic             req, busy, urgent, cmd_valid;
  logic [1:0]       cmd_op;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int n_ref = 0;
  int t_ref = -1;
  int t_prea = -1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  refsch_top #(.TREFI(TREFI), .TRP(TRP), .TRFC(TRFC), .MAX_PEND(MAX_PEND), .NBANK(NBANK)) u0 (
    .clk(clk), .rst_n(rst_n), .grant(grant), .bank_open(bank_open), .ext_pre(ext_pre),
    .req(req), .busy(busy), .urgent(urgent), .cmd_valid(cmd_valid), .cmd_op(cmd_op)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle-ending monitor: records command times, checks spacing per command
  always @(posedge clk) begin
    if (!rst_n) cyc = 0;
    else begin
      if (cmd_valid) chk("R3 command while busy", int'(busy), 1);
      if (cmd_valid && cmd_op == 2'b10) begin
        if (n_ref > 0) chk("R7 refresh spacing ok", int'(cyc - t_ref >= TRFC), 1);
        n_ref++;
        t_ref = cyc;
      end
      if (cmd_valid && cmd_op == 2'b01) t_prea = cyc;
      cyc++;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset req", int'(req), 0);
    chk("R2 reset busy", int'(busy), 0);
    chk("R2 reset urgent", int'(urgent), 0);
    chk("R2 reset cmd_valid", int'(cmd_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_req(output int t_req);
    while (!req) @(negedge clk);
    t_req = cyc;
    chk("R1 first request cycle", t_req, TREFI + 1);
  endtask

  task automatic t_backlog(input int t_req, output int t_urg);
    while (!urgent) @(negedge clk);
    t_urg = cyc;
    chk("R8 urgent delay", t_urg - t_req, (MAX_PEND - 1) * TREFI - 1);
    chk("R2 nothing issued without grant", n_ref, 0);
    chk("R2 req held while withheld", int'(req), 1);
  endtask

  task automatic t_drain(input int t_urg);
    int g, base;
    while (cyc < t_urg + 2 * TREFI) @(negedge clk);
    base = n_ref;
    g = cyc;
    bank_open = 4'b0101;
    grant = 1'b1;
    @(negedge clk);
    bank_open = '0;
    while (n_ref == base) @(negedge clk);
    chk("R4 close-all after grant", t_prea, g + 1);
    chk("R4 refresh after close-all", t_ref, g + 1 + TRP);
    while (busy) @(negedge clk);
    chk("R3 busy end", cyc, t_ref + TRFC);
    while (cyc < g + 38) @(negedge clk);
    chk("R8 drained count", n_ref - base, MAX_PEND);
    chk("R8 urgent cleared", int'(urgent), 0);
    grant = 1'b0;
  endtask

  task automatic t_skip();
    int r, base, p0;
    while (!req) @(negedge clk);
    r = cyc; base = n_ref; p0 = t_prea;
    grant = 1'b1;
    while (n_ref == base) @(negedge clk);
    grant = 1'b0;
    chk("R5 refresh two after grant", t_ref, r + 2);
    chk("R5 no close-all", t_prea, p0);
    while (busy) @(negedge clk);
    chk("R3 busy end skip path", cyc, t_ref + TRFC);
  endtask

  task automatic t_recent_pre();
    int r, base, p0;
    while (!req) @(negedge clk);
    r = cyc; base = n_ref; p0 = t_prea;
    ext_pre = 1'b1;
    grant = 1'b1;
    @(negedge clk);
    ext_pre = 1'b0;
    while (n_ref == base) @(negedge clk);
    grant = 1'b0;
    chk("R6 refresh after external precharge", t_ref, r + TRP);
    chk("R6 no close-all", t_prea, p0);
  endtask

  task automatic t_rate();
    int n0, ok;
    grant = 1'b1;
    n0 = n_ref;
    repeat (20 * TREFI) @(negedge clk);
    grant = 1'b0;
    ok = ((n_ref - n0) >= 19 && (n_ref - n0) <= 21) ? 1 : 0;
    chk("R1 average refresh rate", ok, 1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int t_req, t_urg;
    @(negedge clk);
    t_reset();
    t_first_req(t_req);
    t_backlog(t_req, t_urg);
    t_drain(t_urg);
    t_skip();
    t_recent_pre();
    t_rate();
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end
endmodule